// File: doc/BRIEF.md
# Message Packet Router and Mailbox Mapper

This block sits behind the receive FIFOs of a serial packet endpoint. It looks at the header of each incoming packet and keeps only packets that carry message data. Every other packet is handed on to other logical-layer handlers, and its payload is consumed without being stored.

For each kept packet, the payload bytes are written one by one into a payload buffer of up to 256 bytes. Once the last byte of the segment is in, the block issues a single DMA write request. The address of that request is the base address of the packet's mailbox plus the segment's offset inside the message. The last segment of a message also produces a buffer-descriptor record for that mailbox's queue.

The per-mailbox base addresses are held in a small table that is loaded through a plain write port. A segment longer than the buffer raises an error pulse instead of a DMA request.

Top module: `msg_mbox_router`

## Requirements
- R1: After reset, routeMsg, routeOther, bufWrEn, dmaValid, descValid and segErr are all low.
- R2: A header with format type 11 (hdrFtype = 4'd11), seen while idle, is accepted: routeMsg pulses for one cycle, in the cycle after the header.
- R3: A header with format type 13 is accepted only when its transaction type is 1. With any other transaction type, routeOther pulses instead of routeMsg.
- R4: A header with any other format type pulses routeOther in the cycle after the header. None of the payload that follows produces a buffer write, a DMA request or a descriptor.
- R5: For an accepted packet, each payload byte is written in the same cycle it is presented. The write address starts at 0 and rises by one per byte, and the write data equals the input byte.
- R6: dmaValid pulses exactly one cycle after the last payload byte is taken, and dmaLen equals the number of bytes in the segment.
- R7: dmaAddr equals base[mailbox] + segment number × (8 << size code). A size code above 5 is treated as 5, which gives a 256-byte segment.
- R8: A payload of exactly 256 bytes is accepted. A payload longer than 256 bytes writes only its first 256 bytes, raises segErr one cycle after its last byte, and produces no DMA request.
- R9: When the segment number equals the header's last-segment field, descValid pulses together with dmaValid. It carries the mailbox in descMbox and the mailbox base address in descAddr. For other segments, descValid stays low.
- R10: cfgWe loads cfgBase into table entry cfgIdx. Every entry resets to zero.
- R11: A header that arrives while a payload is being taken in is ignored: it raises neither routeMsg nor routeOther, and the segment in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header sideband valid |
| hdrFtype | input | 4 | Packet format type |
| hdrTtype | input | 4 | Transaction type |
| hdrMbox | input | MBOX_W | Mailbox number |
| hdrSegNum | input | SEG_W | Segment number within the message |
| hdrLastSeg | input | SEG_W | Number of the message's final segment |
| hdrSizeCode | input | 3 | Standard segment size code (8 << code bytes) |
| byteValid | input | 1 | Payload byte valid |
| byteData | input | 8 | Payload byte |
| byteLast | input | 1 | Marks the last payload byte |
| cfgWe | input | 1 | Base table write enable |
| cfgIdx | input | MBOX_W | Base table entry to write |
| cfgBase | input | ADDR_W | Base address to load |
| routeMsg | output | 1 | Packet accepted as message data |
| routeOther | output | 1 | Packet passed to other handlers |
| bufWrEn | output | 1 | Payload buffer write strobe |
| bufWrAddr | output | BUF_AW | Payload buffer byte address |
| bufWrData | output | 8 | Payload buffer write data |
| dmaValid | output | 1 | DMA write request |
| dmaAddr | output | ADDR_W | DMA destination address |
| dmaLen | output | LEN_W | DMA byte count |
| descValid | output | 1 | Buffer-descriptor record valid |
| descMbox | output | MBOX_W | Mailbox of the completed message |
| descAddr | output | ADDR_W | Start address of the completed message |
| segErr | output | 1 | Oversized segment discarded |

## Verification
The bench counts rising edges. A routing pulse must appear exactly one edge after the edge that takes the header. A DMA request or an error pulse must appear one edge after the edge that takes the last byte. Buffer writes are combinational and are checked at the edge that takes each byte. All inputs change on the falling edge, and a monitor samples the outputs on the rising edge, before the registers update. The cycle stamp of each event therefore fixes its latency without relying on process order.

// File: rtl/msg_router_pkg.sv
package msg_router_pkg;

  localparam logic [3:0] FT_MSG    = 4'd11;
  localparam logic [3:0] FT_ALT    = 4'd13;
  localparam logic [3:0] TT_ALT_OK = 4'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SKIP
  } rtState_t;

  typedef struct packed {
    logic latchHdr;
    logic clrCnt;
    logic incCnt;
    logic markAccept;
    logic markReject;
    logic issueDma;
    logic flagErr;
  } ctrlStrobes_t;

endpackage

// File: rtl/msg_router_basetab.sv
module msg_router_basetab #(
  parameter int ADDR_W = 32,
  parameter int MBOX_W = 2,
  localparam int NUM_ENT = 1 << MBOX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [MBOX_W-1:0] wIdx,
  input  logic [ADDR_W-1:0] wData,
  input  logic [MBOX_W-1:0] rIdx,
  output logic [ADDR_W-1:0] rData
);

  logic [NUM_ENT-1:0][ADDR_W-1:0] tab;

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ENT; e++) begin
      if (!rstN) begin
        tab[e] <= '0;
      end else if (we && (wIdx == MBOX_W'(e))) begin
        tab[e] <= wData;
      end
    end
  end

  assign rData = tab[rIdx];

endmodule

// File: rtl/msg_router_ctrl.sv
module msg_router_ctrl
  import msg_router_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hdrValid,
  input  logic         hdrIsMsg,
  input  logic         byteValid,
  input  logic         byteLast,
  input  logic         cntFull,
  output ctrlStrobes_t strobes,
  output logic         inCapture
);

  rtState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (hdrValid) begin
          strobes.latchHdr = 1'b1;
          strobes.clrCnt   = 1'b1;
          if (hdrIsMsg) begin
            strobes.markAccept = 1'b1;
            stateNext          = ST_CAPT;
          end else begin
            strobes.markReject = 1'b1;
            stateNext          = ST_SKIP;
          end
        end
      end
      ST_CAPT: begin
        if (byteValid) begin
          strobes.incCnt = !cntFull;
          if (byteLast) begin
            strobes.issueDma = !cntFull;
            strobes.flagErr  = cntFull;
            stateNext        = ST_IDLE;
          end
        end
      end
      ST_SKIP: begin
        if (byteValid && byteLast) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inCapture = (state == ST_CAPT);

endmodule

// File: rtl/msg_router_dp.sv
module msg_router_dp
  import msg_router_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MBOX_W    = 2,
  parameter int SEG_W     = 4,
  parameter int BUF_BYTES = 256,
  localparam int BUF_AW   = $clog2(BUF_BYTES),
  localparam int LEN_W    = BUF_AW + 1,
  localparam int MAX_CODE = BUF_AW - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              inCapture,
  input  logic [3:0]        hdrFtype,
  input  logic [3:0]        hdrTtype,
  input  logic [MBOX_W-1:0] hdrMbox,
  input  logic [SEG_W-1:0]  hdrSegNum,
  input  logic [SEG_W-1:0]  hdrLastSeg,
  input  logic [2:0]        hdrSizeCode,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              cfgWe,
  input  logic [MBOX_W-1:0] cfgIdx,
  input  logic [ADDR_W-1:0] cfgBase,
  output logic              hdrIsMsg,
  output logic              cntFull,
  output logic              routeMsg,
  output logic              routeOther,
  output logic              bufWrEn,
  output logic [BUF_AW-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              dmaValid,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic              descValid,
  output logic [MBOX_W-1:0] descMbox,
  output logic [ADDR_W-1:0] descAddr,
  output logic              segErr
);

  logic [MBOX_W-1:0] mboxQ;
  logic [SEG_W-1:0]  segQ, lastSegQ;
  logic [2:0]        sizeQ;
  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] baseSel;
  logic [2:0]        effSize;
  logic [3:0]        shiftAmt;
  logic [ADDR_W-1:0] segOff;

  assign hdrIsMsg = (hdrFtype == FT_MSG) ||
                    ((hdrFtype == FT_ALT) && (hdrTtype == TT_ALT_OK));

  assign cntFull   = (cnt == LEN_W'(BUF_BYTES));
  assign bufWrEn   = inCapture && byteValid && !cntFull;
  assign bufWrAddr = cnt[BUF_AW-1:0];
  assign bufWrData = byteData;

  msg_router_basetab #(
    .ADDR_W(ADDR_W),
    .MBOX_W(MBOX_W)
  ) u_basetab (
    .clk  (clk),
    .rstN (rstN),
    .we   (cfgWe),
    .wIdx (cfgIdx),
    .wData(cfgBase),
    .rIdx (mboxQ),
    .rData(baseSel)
  );

  always_comb begin
    effSize  = (sizeQ > 3'(MAX_CODE)) ? 3'(MAX_CODE) : sizeQ;
    shiftAmt = 4'd3 + {1'b0, effSize};
    segOff   = ADDR_W'(segQ) << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mboxQ    <= '0;
      segQ     <= '0;
      lastSegQ <= '0;
      sizeQ    <= '0;
    end else if (strobes.latchHdr) begin
      mboxQ    <= hdrMbox;
      segQ     <= hdrSegNum;
      lastSegQ <= hdrLastSeg;
      sizeQ    <= hdrSizeCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrCnt) cnt <= '0;
    else if (strobes.incCnt)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeMsg   <= 1'b0;
      routeOther <= 1'b0;
      dmaValid   <= 1'b0;
      dmaAddr    <= '0;
      dmaLen     <= '0;
      descValid  <= 1'b0;
      descMbox   <= '0;
      descAddr   <= '0;
      segErr     <= 1'b0;
    end else begin
      routeMsg   <= strobes.markAccept;
      routeOther <= strobes.markReject;
      dmaValid   <= strobes.issueDma;
      segErr     <= strobes.flagErr;
      descValid  <= strobes.issueDma && (segQ == lastSegQ);
      if (strobes.issueDma) begin
        dmaAddr  <= baseSel + segOff;
        dmaLen   <= cnt + 1'b1;
        descMbox <= mboxQ;
        descAddr <= baseSel;
      end
    end
  end

endmodule

// File: rtl/msg_mbox_router.sv
module msg_mbox_router
  import msg_router_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MBOX_W    = 2,
  parameter int SEG_W     = 4,
  parameter int BUF_BYTES = 256,
  localparam int BUF_AW   = $clog2(BUF_BYTES),
  localparam int LEN_W    = BUF_AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [3:0]        hdrFtype,
  input  logic [3:0]        hdrTtype,
  input  logic [MBOX_W-1:0] hdrMbox,
  input  logic [SEG_W-1:0]  hdrSegNum,
  input  logic [SEG_W-1:0]  hdrLastSeg,
  input  logic [2:0]        hdrSizeCode,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteLast,
  input  logic              cfgWe,
  input  logic [MBOX_W-1:0] cfgIdx,
  input  logic [ADDR_W-1:0] cfgBase,
  output logic              routeMsg,
  output logic              routeOther,
  output logic              bufWrEn,
  output logic [BUF_AW-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              dmaValid,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic              descValid,
  output logic [MBOX_W-1:0] descMbox,
  output logic [ADDR_W-1:0] descAddr,
  output logic              segErr
);

  ctrlStrobes_t strobes;
  logic         inCapture;
  logic         hdrIsMsg;
  logic         cntFull;

  msg_router_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .hdrIsMsg (hdrIsMsg),
    .byteValid(byteValid),
    .byteLast (byteLast),
    .cntFull  (cntFull),
    .strobes  (strobes),
    .inCapture(inCapture)
  );

  msg_router_dp #(
    .ADDR_W   (ADDR_W),
    .MBOX_W   (MBOX_W),
    .SEG_W    (SEG_W),
    .BUF_BYTES(BUF_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inCapture  (inCapture),
    .hdrFtype   (hdrFtype),
    .hdrTtype   (hdrTtype),
    .hdrMbox    (hdrMbox),
    .hdrSegNum  (hdrSegNum),
    .hdrLastSeg (hdrLastSeg),
    .hdrSizeCode(hdrSizeCode),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .cfgWe      (cfgWe),
    .cfgIdx     (cfgIdx),
    .cfgBase    (cfgBase),
    .hdrIsMsg   (hdrIsMsg),
    .cntFull    (cntFull),
    .routeMsg   (routeMsg),
    .routeOther (routeOther),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .dmaValid   (dmaValid),
    .dmaAddr    (dmaAddr),
    .dmaLen     (dmaLen),
    .descValid  (descValid),
    .descMbox   (descMbox),
    .descAddr   (descAddr),
    .segErr     (segErr)
  );

endmodule

// File: rtl/msg_router_checker.sv
module msg_router_checker #(
  parameter int BUF_BYTES = 256,
  parameter int LEN_W     = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             routeMsg,
  input logic             routeOther,
  input logic             bufWrEn,
  input logic             dmaValid,
  input logic [LEN_W-1:0] dmaLen,
  input logic             descValid,
  input logic             segErr
);

  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({routeMsg, routeOther, dmaValid, segErr}));

  assert_desc_needs_dma_R9: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> dmaValid);

  assert_len_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> ((dmaLen != '0) && (dmaLen <= LEN_W'(BUF_BYTES))));

  assert_no_write_on_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    routeOther |-> !bufWrEn);

  assert_err_then_no_dma_R8: assert property (@(posedge clk) disable iff (!rstN)
    segErr |=> !dmaValid);

endmodule

bind msg_mbox_router msg_router_checker #(
  .BUF_BYTES(BUF_BYTES),
  .LEN_W    (LEN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .routeMsg  (routeMsg),
  .routeOther(routeOther),
  .bufWrEn   (bufWrEn),
  .dmaValid  (dmaValid),
  .dmaLen    (dmaLen),
  .descValid (descValid),
  .segErr    (segErr)
);

// File: tb/msg_mbox_router_bench.sv
`timescale 1ns/1ps
module msg_mbox_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrValid = 1'b0;
  logic [3:0]  hdrFtype = '0;
  logic [3:0]  hdrTtype = '0;
  logic [1:0]  hdrMbox = '0;
  logic [3:0]  hdrSegNum = '0;
  logic [3:0]  hdrLastSeg = '0;
  logic [2:0]  hdrSizeCode = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteLast = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgBase = '0;
  logic        routeMsg, routeOther, bufWrEn, dmaValid, descValid, segErr;
  logic [7:0]  bufWrAddr, bufWrData;
  logic [31:0] dmaAddr, descAddr;
  logic [8:0]  dmaLen;
  logic [1:0]  descMbox;

  always #2.5 clk = ~clk;

  msg_mbox_router u_msg_mbox_router (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrFtype(hdrFtype),
    .hdrTtype(hdrTtype), .hdrMbox(hdrMbox), .hdrSegNum(hdrSegNum),
    .hdrLastSeg(hdrLastSeg), .hdrSizeCode(hdrSizeCode), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgBase(cfgBase), .routeMsg(routeMsg), .routeOther(routeOther),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .descValid(descValid), .descMbox(descMbox), .descAddr(descAddr),
    .segErr(segErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int cyc = 0;
  int wrCount, wrBad, nAcc, nPass, nDma, nDesc, nErr;
  int accCyc, passCyc, dmaCyc, errCyc, hdrCyc, lastCyc;
  logic [31:0] seenDmaAddr, seenDescAddr;
  logic [8:0]  seenDmaLen;
  logic [1:0]  seenDescMbox;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + 8'h35);
  endfunction

  // Monitor: reads outputs as they stood before each rising edge.
  always @(posedge clk) begin
    if (rstN) begin
      if (bufWrEn) begin
        if (bufWrAddr !== 8'(wrCount) || bufWrData !== pat(wrCount)) wrBad++;
        wrCount++;
      end
      if (routeMsg)   begin nAcc++;  accCyc  = cyc; end
      if (routeOther) begin nPass++; passCyc = cyc; end
      if (dmaValid) begin
        nDma++; dmaCyc = cyc; seenDmaAddr = dmaAddr; seenDmaLen = dmaLen;
      end
      if (descValid) begin
        nDesc++; seenDescAddr = descAddr; seenDescMbox = descMbox;
      end
      if (segErr) begin nErr++; errCyc = cyc; end
    end
    cyc++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    wrCount = 0; wrBad = 0; nAcc = 0; nPass = 0; nDma = 0; nDesc = 0; nErr = 0;
    accCyc = -1; passCyc = -1; dmaCyc = -1; errCyc = -1;
  endtask

  task automatic sendPkt(input logic [3:0] ft, input logic [3:0] tt, input logic [1:0] mb,
                         input logic [3:0] seg, input logic [3:0] lastSeg,
                         input logic [2:0] sz, input int nBytes, input bit midHdr);
    @(negedge clk);
    clearMon();
    hdrValid = 1'b1; hdrFtype = ft; hdrTtype = tt; hdrMbox = mb;
    hdrSegNum = seg; hdrLastSeg = lastSeg; hdrSizeCode = sz;
    hdrCyc = cyc;
    @(negedge clk);
    hdrValid = 1'b0;
    for (int i = 0; i < nBytes; i++) begin
      byteValid = 1'b1;
      byteData  = pat(i);
      byteLast  = (i == nBytes - 1);
      if (i == nBytes - 1) lastCyc = cyc;
      if (midHdr && i == 1) begin
        hdrValid = 1'b1; hdrFtype = 4'd10; hdrMbox = 2'd0; hdrSegNum = 4'd9;
      end
      @(negedge clk);
      hdrValid = 1'b0;
    end
    byteValid = 1'b0; byteLast = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setBase(input logic [1:0] idx, input logic [31:0] b);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgBase = b;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic testReset();
    // R1
    check(!routeMsg && !routeOther && !bufWrEn, "R1 route/write idle",
          {routeMsg, routeOther, bufWrEn}, 0);
    check(!dmaValid && !descValid && !segErr, "R1 dma/desc/err idle",
          {dmaValid, descValid, segErr}, 0);
  endtask

  task automatic testUnconfigured();
    // R10 reset base zero, R2 accept type 11, R6 timing and length
    sendPkt(4'd11, 4'd0, 2'd3, 4'd0, 4'd5, 3'd0, 4, 1'b0);
    check(nAcc == 1 && nPass == 0, "R2 type 11 accepted", nAcc, 1);
    check(accCyc == hdrCyc + 1, "R2 accept latency", accCyc - hdrCyc, 1);
    check(nDma == 1 && seenDmaAddr == 32'h0, "R10 reset base zero", seenDmaAddr, 0);
    check(dmaCyc == lastCyc + 1, "R6 dma latency", dmaCyc - lastCyc, 1);
    check(seenDmaLen == 9'd4, "R6 dma length", seenDmaLen, 4);
    check(wrCount == 4 && wrBad == 0, "R5 buffer writes", wrBad, 0);
  endtask

  task automatic testMidSegment();
    // R7 address from base and segment offset; R9 no descriptor mid-message
    sendPkt(4'd11, 4'd0, 2'd1, 4'd2, 4'd3, 3'd2, 32, 1'b0);
    check(nDma == 1 && seenDmaAddr == 32'h2000_0140, "R7 segment address",
          seenDmaAddr, 32'h2000_0140);
    check(seenDmaLen == 9'd32, "R6 length 32", seenDmaLen, 32);
    check(nDesc == 0, "R9 no descriptor mid-message", nDesc, 0);
    check(wrCount == 32 && wrBad == 0, "R5 sequential writes", wrBad, 0);
  endtask

  task automatic testAltFullBuffer();
    // R3 type 13 / ttype 1, R8 exactly 256 bytes, R9 descriptor on final segment
    sendPkt(4'd13, 4'd1, 2'd2, 4'd3, 4'd3, 3'd5, 256, 1'b0);
    check(nAcc == 1 && nPass == 0, "R3 type 13 ttype 1 accepted", nAcc, 1);
    check(nDma == 1 && seenDmaLen == 9'd256, "R8 256-byte segment", seenDmaLen, 256);
    check(seenDmaAddr == 32'h3000_0300, "R7 address size 256", seenDmaAddr, 32'h3000_0300);
    check(nDesc == 1 && seenDescMbox == 2'd2, "R9 descriptor mailbox", seenDescMbox, 2);
    check(seenDescAddr == 32'h3000_0000, "R9 descriptor address", seenDescAddr, 32'h3000_0000);
    check(wrCount == 256 && wrBad == 0, "R5 full buffer writes", wrCount, 256);
  endtask

  task automatic testAltReject();
    // R3 type 13 with another transaction type is forwarded
    sendPkt(4'd13, 4'd0, 2'd0, 4'd0, 4'd0, 3'd0, 6, 1'b0);
    check(nPass == 1 && nAcc == 0, "R3 type 13 ttype 0 forwarded", nPass, 1);
    check(passCyc == hdrCyc + 1, "R3 forward latency", passCyc - hdrCyc, 1);
    check(wrCount == 0 && nDma == 0, "R4 no write no dma", wrCount + nDma, 0);
  endtask

  task automatic testOtherType();
    // R4 other format type forwarded, payload dropped
    sendPkt(4'd10, 4'd1, 2'd1, 4'd0, 4'd0, 3'd0, 5, 1'b0);
    check(nPass == 1 && nAcc == 0, "R4 type 10 forwarded", nPass, 1);
    check(wrCount == 0 && nDma == 0 && nDesc == 0, "R4 payload dropped",
          wrCount + nDma + nDesc, 0);
  endtask

  task automatic testSizeClamp();
    // R7 size code 7 behaves as 5
    sendPkt(4'd11, 4'd0, 2'd0, 4'd1, 4'd2, 3'd7, 8, 1'b0);
    check(seenDmaAddr == 32'h1000_0100, "R7 size clamp", seenDmaAddr, 32'h1000_0100);
  endtask

  task automatic testOverflow();
    // R8 257 bytes: only 256 written, error, no dma
    sendPkt(4'd11, 4'd0, 2'd3, 4'd0, 4'd0, 3'd5, 257, 1'b0);
    check(wrCount == 256 && wrBad == 0, "R8 writes capped", wrCount, 256);
    check(nErr == 1 && errCyc == lastCyc + 1, "R8 error pulse", nErr, 1);
    check(nDma == 0 && nDesc == 0, "R8 no dma on overflow", nDma, 0);
  endtask

  task automatic testHeaderDuringCapture();
    // R11 header during payload ignored
    sendPkt(4'd11, 4'd0, 2'd3, 4'd1, 4'd1, 3'd0, 6, 1'b1);
    check(nAcc == 1 && nPass == 0, "R11 stray header ignored", nPass, 0);
    check(nDma == 1 && seenDmaAddr == 32'h4000_0048, "R11 segment unchanged",
          seenDmaAddr, 32'h4000_0048);
    check(nDesc == 1 && seenDescMbox == 2'd3, "R11 descriptor unchanged", seenDescMbox, 3);
  endtask

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testUnconfigured();
    setBase(2'd0, 32'h1000_0000);
    setBase(2'd1, 32'h2000_0100);
    setBase(2'd2, 32'h3000_0000);
    setBase(2'd3, 32'h4000_0040);
    testMidSegment();
    testAltFullBuffer();
    testAltReject();
    testOtherType();
    testSizeClamp();
    testOverflow();
    testHeaderDuringCapture();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule